// File: doc/BRIEF.md
# Queue Doorbell and Completion Ring Manager

This block keeps the pointer state of a set of submission and completion rings that live in host memory. It decodes doorbell writes, which move a submission ring's tail or a completion ring's head. It buffers finished-command reports and turns them into completion-entry memory writes. The block does not fetch commands or execute them. It tells the fetch side through a per-queue "work pending" strobe, and that side reports each command it consumes through a pop port, which moves the submission head.

Queues are created through a one-cycle configuration port. A completion queue is given a base address, an entry count and an interrupt enable. A submission queue is given an entry count and the completion queue it reports to. Each completion queue owns a small pending store. Up to one entry is posted per cycle, from the lowest-numbered queue that has work and room. Each entry carries a phase bit that flips every time the ring wraps, so the host can tell new entries from stale ones.

Top module: `qdb_ring_mgr`

## Requirements
- R1: After reset no queue exists, and `cqe_valid`, `irq_req` and `sq_work` are all zero.
- R2: The doorbell region starts at offset 0x1000. The submission-tail slot of queue q is at 0x1000+8q and the completion-head slot is at 0x1004+8q. An accepted tail write stores the value and pulses `sq_work[q]` in the next cycle.
- R3: A doorbell write is ignored if any of these holds: the offset is below 0x1000, the offset is not a multiple of 4, the queue has not been created, or the value is greater than or equal to the ring's entry count.
- R4: An entry for completion ring c is written to base(c) + tail(c)·2^CQES. Its 16-bit status word is {status[14:0], phase}.
- R5: A new completion ring starts at tail 0 with phase 1. Each time its tail steps past entry count−1, it returns to 0 and the phase inverts.
- R6: A completion ring is full when (tail+1) mod size equals head. Nothing is posted to a full ring, and its pending reports wait in arrival order.
- R7: A head doorbell on a ring that was full pulses `sq_work` for every created submission queue bound to that ring, and posting resumes.
- R8: `irq_req[c]` pulses after each entry posted to ring c and after an accepted head write that leaves tail ≠ head. It never pulses if ring c was created with interrupts disabled.
- R9: Each entry carries the command id, the submission queue id and that submission queue's current head. A pop moves the head to (head+1) mod size and is ignored when head equals tail.
- R10: A completion report is dropped if its submission queue is not created or if its completion ring's pending store is full.
- R11: A full ring does not hold back posting to other rings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Create a queue this cycle |
| cfg_is_cq | input | 1 | 1: completion ring, 0: submission ring |
| cfg_qid | input | QW | Queue number |
| cfg_size | input | 16 | Entry count (at least 2) |
| cfg_base | input | ADDR_W | Completion ring base address |
| cfg_cqid | input | QW | Completion ring a submission queue reports to |
| cfg_irq_en | input | 1 | Interrupt enable for a completion ring |
| db_valid | input | 1 | Doorbell write strobe |
| db_off | input | OFF_W | Doorbell byte offset |
| db_data | input | 16 | New tail or head value |
| sq_pop | input | 1 | Fetch side consumed one command |
| sq_pop_qid | input | QW | Queue of the consumed command |
| cmp_valid | input | 1 | Completion report strobe |
| cmp_cid | input | CID_W | Command id |
| cmp_status | input | ST_W | Status code |
| cmp_sqid | input | QW | Submission queue of the command |
| cqe_valid | output | 1 | Entry memory write request |
| cqe_addr | output | ADDR_W | Entry address |
| cqe_cid | output | CID_W | Entry command id |
| cqe_status_word | output | ST_W+1 | {status, phase} |
| cqe_sqid | output | QW | Entry submission queue id |
| cqe_sqhead | output | 16 | Submission head at posting |
| irq_req | output | NQ | Per completion ring interrupt pulse |
| sq_work | output | NQ | Per submission queue work-pending pulse |

## Verification
A tail doorbell is swept through values on both sides of the ring size, which shows where the bound check sits. Misaligned, out-of-region and uncreated-queue offsets are then written to tell decode rejection apart from acceptance. A burst of reports is sent that is longer than the ring, so posting must stop at the full point. Head writes then free one or two slots, which shows the restart, the wrap with its phase flip and the interrupt rule. One report goes to a second ring while the first is stalled, which separates per-ring blocking from global blocking. A pop on an empty queue is shown to be ignored through the head value carried in a later entry.

// File: rtl/qdb_pkg.sv
package qdb_pkg;
  localparam int QDB_PTR_W = 16;
  typedef logic [QDB_PTR_W-1:0] qptr_t;

  // next slot of a ring with 'size' entries
  function automatic qptr_t ring_next(input qptr_t p, input qptr_t size);
    logic [QDB_PTR_W:0] n;
    n = {1'b0, p} + 1'b1;
    return (n >= {1'b0, size}) ? '0 : n[QDB_PTR_W-1:0];
  endfunction

  function automatic logic ring_full(input qptr_t tail, input qptr_t head, input qptr_t size);
    return ring_next(tail, size) == head;
  endfunction
endpackage

// File: rtl/qdb_db_decode.sv
module qdb_db_decode #(
  parameter int NQ      = 4,
  parameter int OFF_W   = 16,
  parameter int DB_BASE = 'h1000
) (
  input  logic             db_valid,
  input  logic [OFF_W-1:0] db_off,
  output logic [NQ-1:0]    sq_hit,
  output logic [NQ-1:0]    cq_hit
);
  logic [OFF_W-1:0] rel;
  logic [OFF_W-4:0] qn;
  logic             in_region;

  always_comb begin
    rel       = db_off - OFF_W'(DB_BASE);
    qn        = rel[OFF_W-1:3];
    in_region = db_valid && (db_off >= OFF_W'(DB_BASE)) && (rel[1:0] == 2'b00);
    for (int q = 0; q < NQ; q++) begin
      sq_hit[q] = in_region && (qn == (OFF_W-3)'(q)) && !rel[2];
      cq_hit[q] = in_region && (qn == (OFF_W-3)'(q)) &&  rel[2];
    end
  end
endmodule

// File: rtl/qdb_pend_fifo.sv
module qdb_pend_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;

  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= din;
        wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      end
      if (pop) rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      count <= count + (push ? 1'b1 : 1'b0) - (pop ? 1'b1 : 1'b0);
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/qdb_ring_mgr.sv
module qdb_ring_mgr
  import qdb_pkg::*;
#(
  parameter int NQ         = 4,
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 16,
  parameter int CID_W      = 16,
  parameter int ST_W       = 15,
  parameter int CQES       = 4,
  parameter int PEND_DEPTH = 4,
  localparam int QW        = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int PW        = QDB_PTR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic              cfg_is_cq,
  input  logic [QW-1:0]     cfg_qid,
  input  logic [PW-1:0]     cfg_size,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [QW-1:0]     cfg_cqid,
  input  logic              cfg_irq_en,
  input  logic              db_valid,
  input  logic [OFF_W-1:0]  db_off,
  input  logic [PW-1:0]     db_data,
  input  logic              sq_pop,
  input  logic [QW-1:0]     sq_pop_qid,
  input  logic              cmp_valid,
  input  logic [CID_W-1:0]  cmp_cid,
  input  logic [ST_W-1:0]   cmp_status,
  input  logic [QW-1:0]     cmp_sqid,
  output logic              cqe_valid,
  output logic [ADDR_W-1:0] cqe_addr,
  output logic [CID_W-1:0]  cqe_cid,
  output logic [ST_W:0]     cqe_status_word,
  output logic [QW-1:0]     cqe_sqid,
  output logic [PW-1:0]     cqe_sqhead,
  output logic [NQ-1:0]     irq_req,
  output logic [NQ-1:0]     sq_work
);
  localparam int PEW = QW + ST_W + CID_W;

  function automatic logic [ADDR_W-1:0] entry_addr(input logic [ADDR_W-1:0] base, input qptr_t tail);
    return base + (ADDR_W'(tail) << CQES);
  endfunction

  // submission ring state
  logic [NQ-1:0] sq_on;
  qptr_t         sq_size [NQ];
  qptr_t         sq_head [NQ];
  qptr_t         sq_tail [NQ];
  logic [QW-1:0] sq_cq   [NQ];
  // completion ring state
  logic [NQ-1:0]     cq_on, cq_phase, cq_ien;
  qptr_t             cq_size [NQ];
  qptr_t             cq_head [NQ];
  qptr_t             cq_tail [NQ];
  logic [ADDR_W-1:0] cq_base [NQ];

  // named internal events
  logic [NQ-1:0] db_sq_hit, db_cq_hit;
  logic [NQ-1:0] sq_tail_wr, cq_head_wr, cq_full, cq_restart;
  logic [NQ-1:0] cfg_sq_hit, cfg_cq_hit;
  logic [NQ-1:0] pend_push, pend_empty, pend_full, post_cand, post_oh;
  logic [NQ-1:0] sq_pop_ok, sq_wake;
  logic [PEW-1:0] pend_dout [NQ];
  logic [QW-1:0]  post_q, cmp_cq;
  logic           post_any, cmp_ok;
  logic [PEW-1:0] sel;

  qdb_db_decode #(.NQ(NQ), .OFF_W(OFF_W), .DB_BASE('h1000)) u_dec (
    .db_valid(db_valid), .db_off(db_off), .sq_hit(db_sq_hit), .cq_hit(db_cq_hit)
  );

  assign cmp_cq = sq_cq[cmp_sqid];
  assign cmp_ok = cmp_valid && sq_on[cmp_sqid] && cq_on[cmp_cq] && !pend_full[cmp_cq];

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      cfg_sq_hit[q] = cfg_valid && !cfg_is_cq && (cfg_qid == QW'(q));
      cfg_cq_hit[q] = cfg_valid &&  cfg_is_cq && (cfg_qid == QW'(q));
      sq_tail_wr[q] = db_sq_hit[q] && sq_on[q] && (db_data < sq_size[q]);
      cq_head_wr[q] = db_cq_hit[q] && cq_on[q] && (db_data < cq_size[q]);
      cq_full[q]    = ring_full(cq_tail[q], cq_head[q], cq_size[q]);
      cq_restart[q] = cq_head_wr[q] && cq_full[q];
      pend_push[q]  = cmp_ok && (cmp_cq == QW'(q));
      post_cand[q]  = cq_on[q] && !pend_empty[q] && !cq_full[q];
      sq_pop_ok[q]  = sq_pop && (sq_pop_qid == QW'(q)) && sq_on[q] && (sq_head[q] != sq_tail[q]);
    end
    for (int q = 0; q < NQ; q++) sq_wake[q] = sq_on[q] && cq_restart[sq_cq[q]];
  end

  // lowest-numbered ring with work and room posts
  always_comb begin
    post_oh  = '0;
    post_q   = '0;
    post_any = 1'b0;
    for (int q = 0; q < NQ; q++) begin
      if (post_cand[q] && !post_any) begin
        post_oh[q] = 1'b1;
        post_q     = QW'(q);
        post_any   = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_pend
    qdb_pend_fifo #(.W(PEW), .DEPTH(PEND_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(pend_push[g]), .din({cmp_sqid, cmp_status, cmp_cid}),
      .pop(post_oh[g]), .dout(pend_dout[g]),
      .empty(pend_empty[g]), .full(pend_full[g])
    );
  end

  assign sel = pend_dout[post_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sq_on <= '0; cq_on <= '0; cq_phase <= '0; cq_ien <= '0;
      for (int q = 0; q < NQ; q++) begin
        sq_size[q] <= '0; sq_head[q] <= '0; sq_tail[q] <= '0; sq_cq[q] <= '0;
        cq_size[q] <= '0; cq_head[q] <= '0; cq_tail[q] <= '0; cq_base[q] <= '0;
      end
    end else begin
      for (int q = 0; q < NQ; q++) begin
        if (cfg_sq_hit[q]) begin
          sq_on[q] <= 1'b1; sq_size[q] <= cfg_size; sq_cq[q] <= cfg_cqid;
          sq_head[q] <= '0; sq_tail[q] <= '0;
        end else begin
          if (sq_tail_wr[q]) sq_tail[q] <= db_data;
          if (sq_pop_ok[q])  sq_head[q] <= ring_next(sq_head[q], sq_size[q]);
        end
        if (cfg_cq_hit[q]) begin
          cq_on[q] <= 1'b1; cq_size[q] <= cfg_size; cq_base[q] <= cfg_base;
          cq_ien[q] <= cfg_irq_en; cq_head[q] <= '0; cq_tail[q] <= '0; cq_phase[q] <= 1'b1;
        end else begin
          if (cq_head_wr[q]) cq_head[q] <= db_data;
          if (post_oh[q]) begin
            cq_tail[q] <= ring_next(cq_tail[q], cq_size[q]);
            if (ring_next(cq_tail[q], cq_size[q]) == '0) cq_phase[q] <= ~cq_phase[q];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cqe_valid <= 1'b0; cqe_addr <= '0; cqe_cid <= '0; cqe_status_word <= '0;
      cqe_sqid <= '0; cqe_sqhead <= '0; irq_req <= '0; sq_work <= '0;
    end else begin
      cqe_valid       <= post_any;
      cqe_addr        <= entry_addr(cq_base[post_q], cq_tail[post_q]);
      cqe_cid         <= sel[CID_W-1:0];
      cqe_status_word <= {sel[CID_W +: ST_W], cq_phase[post_q]};
      cqe_sqid        <= sel[CID_W+ST_W +: QW];
      cqe_sqhead      <= sq_head[sel[CID_W+ST_W +: QW]];
      for (int q = 0; q < NQ; q++) begin
        irq_req[q] <= cq_ien[q] && (post_oh[q] || (cq_head_wr[q] && (cq_tail[q] != db_data)));
        sq_work[q] <= sq_tail_wr[q] || sq_wake[q];
      end
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_chk
    // R8
    irq_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req[g] |-> $past(cq_ien[g]));
    // R6
    tail_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (post_oh[g] && !cfg_cq_hit[g]) |=> (cq_tail[g] != $past(cq_tail[g])));
    // R5
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cq_on[g] && $past(cq_on[g]) && !$past(cfg_cq_hit[g]) && cq_tail[g] == '0 && $past(cq_tail[g]) != '0)
        |-> (cq_phase[g] != $past(cq_phase[g])));
  end
endmodule

// File: tb/sim_qdb_ring_mgr.sv
module sim_qdb_ring_mgr;
  localparam int NQ = 4, QW = 2, AW = 32, OW = 16, CW = 16, SW = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_valid = 0, cfg_is_cq = 0, cfg_irq_en = 0;
  logic [QW-1:0] cfg_qid = '0, cfg_cqid = '0, sq_pop_qid = '0, cmp_sqid = '0;
  logic [15:0] cfg_size = '0, db_data = '0;
  logic [AW-1:0] cfg_base = '0;
  logic db_valid = 0, sq_pop = 0, cmp_valid = 0;
  logic [OW-1:0] db_off = '0;
  logic [CW-1:0] cmp_cid = '0;
  logic [SW-1:0] cmp_status = '0;
  logic cqe_valid;
  logic [AW-1:0] cqe_addr;
  logic [CW-1:0] cqe_cid;
  logic [SW:0] cqe_status_word;
  logic [QW-1:0] cqe_sqid;
  logic [15:0] cqe_sqhead;
  logic [NQ-1:0] irq_req, sq_work;

  always #5 clk = ~clk;

  qdb_ring_mgr u0 (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_is_cq(cfg_is_cq), .cfg_qid(cfg_qid),
    .cfg_size(cfg_size), .cfg_base(cfg_base), .cfg_cqid(cfg_cqid), .cfg_irq_en(cfg_irq_en),
    .db_valid(db_valid), .db_off(db_off), .db_data(db_data), .sq_pop(sq_pop), .sq_pop_qid(sq_pop_qid),
    .cmp_valid(cmp_valid), .cmp_cid(cmp_cid), .cmp_status(cmp_status), .cmp_sqid(cmp_sqid),
    .cqe_valid(cqe_valid), .cqe_addr(cqe_addr), .cqe_cid(cqe_cid), .cqe_status_word(cqe_status_word),
    .cqe_sqid(cqe_sqid), .cqe_sqhead(cqe_sqhead), .irq_req(irq_req), .sq_work(sq_work)
  );

  int total = 0, bad = 0, n_cqe = 0;
  int irq_cnt [NQ];
  int work_cnt [NQ];
  logic [AW-1:0] c_addr [16];
  logic [CW-1:0] c_cid [16];
  logic [SW:0]   c_sw [16];
  logic [QW-1:0] c_sq [16];
  logic [15:0]   c_hd [16];
  bit done = 0;

  initial for (int q = 0; q < NQ; q++) begin irq_cnt[q] = 0; work_cnt[q] = 0; end

  always @(negedge clk) if (rst_n) begin
    for (int q = 0; q < NQ; q++) begin
      irq_cnt[q]  += int'(irq_req[q]);
      work_cnt[q] += int'(sq_work[q]);
    end
    if (cqe_valid && n_cqe < 16) begin
      c_addr[n_cqe] = cqe_addr; c_cid[n_cqe] = cqe_cid; c_sw[n_cqe] = cqe_status_word;
      c_sq[n_cqe] = cqe_sqid; c_hd[n_cqe] = cqe_sqhead;
    end
    if (cqe_valid) n_cqe++;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mk(input bit is_cq, input int qid, input int size, input int base, input int cq, input bit ien);
    @(negedge clk);
    cfg_valid = 1; cfg_is_cq = is_cq; cfg_qid = QW'(qid); cfg_size = 16'(size);
    cfg_base = AW'(base); cfg_cqid = QW'(cq); cfg_irq_en = ien;
    @(negedge clk);
    cfg_valid = 0;
  endtask

  task automatic db(input int off, input int val);
    @(negedge clk);
    db_valid = 1; db_off = OW'(off); db_data = 16'(val);
    @(negedge clk);
    db_valid = 0;
  endtask

  task automatic pop(input int qid);
    @(negedge clk);
    sq_pop = 1; sq_pop_qid = QW'(qid);
    @(negedge clk);
    sq_pop = 0;
  endtask

  task automatic cmp(input int cid, input int st, input int sq);
    @(negedge clk);
    cmp_valid = 1; cmp_cid = CW'(cid); cmp_status = SW'(st); cmp_sqid = QW'(sq);
    @(negedge clk);
    cmp_valid = 0;
  endtask

  // check entry e as the k-th posting to ring 1 (size 4, base 0x8000)
  task automatic chk_r1(input int e, input int k);
    int t, ph;
    t = k % 4;
    ph = 1 ^ ((k / 4) & 1);
    chk("R4 addr", c_addr[e], 32'h8000 + t * 16);
    chk("R5 status word", c_sw[e], ((32'h20 + k) << 1) | ph);
    chk("R9 cid", c_cid[e], 32'h10 + k);
    chk("R9 sqid", c_sq[e], 1);
    chk("R9 sq head", c_hd[e], 2);
  endtask

  initial begin
    int w0, w3;
    idle(3);
    chk("R1 cqe_valid", cqe_valid, 0);
    chk("R1 irq", irq_req, 0);
    chk("R1 work", sq_work, 0);
    rst_n = 1;
    db(16'h1008, 1);
    idle(1);
    chk("R1 no queue before create", work_cnt[1], 0);

    mk(1, 1, 4, 32'h8000, 0, 1);
    mk(1, 2, 3, 32'hA000, 0, 0);
    mk(0, 1, 4, 0, 1, 0);
    mk(0, 3, 5, 0, 2, 0);

    // R2 / R3 tail value sweep on queue 1
    for (int v = 0; v < 6; v++) begin
      w0 = work_cnt[1];
      db(16'h1008, v);
      idle(1);
      chk((v < 4) ? "R2 tail accepted" : "R3 tail >= size", work_cnt[1] - w0, (v < 4) ? 1 : 0);
    end
    w0 = work_cnt[1];
    db(16'h1009, 1); db(16'h100A, 1); db(16'h0008, 1);
    idle(1);
    chk("R3 misaligned / below region", work_cnt[1] - w0, 0);
    db(16'h1000, 0); db(16'h1010, 0);
    idle(1);
    chk("R3 uncreated sq", work_cnt[0] + work_cnt[2], 0);
    db(16'h1018, 2);
    idle(1);
    chk("R2 tail slot q3", work_cnt[3], 1);

    // R9 pops: sq1 head -> 2, sq3 head -> 2 with third pop on empty ignored
    pop(1); pop(1);
    pop(3); pop(3); pop(3);

    // R6 burst longer than ring 1
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      cmp_valid = 1; cmp_cid = CW'(16'h10 + i); cmp_status = SW'(16'h20 + i); cmp_sqid = 2'd1;
    end
    @(negedge clk);
    cmp_valid = 0;
    idle(10);
    chk("R6 stops at full", n_cqe, 3);
    chk("R8 irq per post", irq_cnt[1], 3);

    // R10 drops
    cmp(16'h16, 16'h26, 1);
    cmp(16'h17, 16'h27, 1);
    cmp(16'h40, 16'h41, 2);
    // R11 other ring still posts
    cmp(16'h30, 16'h31, 3);
    idle(5);
    chk("R11 other ring posts", n_cqe, 4);
    chk("R4 ring2 addr", c_addr[3], 32'hA000);
    chk("R5 ring2 phase", c_sw[3], (32'h31 << 1) | 1);
    chk("R9 empty pop ignored", c_hd[3], 2);
    chk("R9 ring2 sqid", c_sq[3], 3);
    chk("R8 disabled ring", irq_cnt[2], 0);

    // R3 head >= size ignored
    w0 = work_cnt[1];
    db(16'h100C, 4);
    idle(5);
    chk("R3 head >= size", n_cqe, 4);
    chk("R3 head >= size no restart", work_cnt[1] - w0, 0);

    // R7 restart
    w3 = work_cnt[3];
    db(16'h100C, 3);
    idle(8);
    chk("R7 restart strobe", work_cnt[1] - w0, 1);
    chk("R7 unbound sq quiet", work_cnt[3] - w3, 0);
    chk("R7 posting resumes", n_cqe, 7);
    db(16'h100C, 2);
    idle(5);
    chk("R7 second restart", work_cnt[1] - w0, 2);
    chk("R10 overflow report dropped", n_cqe, 8);
    chk("R8 irq count", irq_cnt[1], 7);

    for (int k = 0; k < 3; k++) chk_r1(k, k);
    for (int k = 3; k < 7; k++) chk_r1(k + 1, k);

    // R8 head write leaving tail != head
    w0 = work_cnt[1];
    db(16'h100C, 0);
    idle(2);
    chk("R8 head write irq", irq_cnt[1], 8);
    chk("R7 no restart when not full", work_cnt[1] - w0, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule